// File: doc/BRIEF.md
# ATAPI Device Status and Host Interrupt Logic

This block holds the device-side status byte that an ATAPI host reads and drives the interrupt request line toward that host. A local controller loads the status byte and pulses a trigger strobe to request a host interrupt. The host-side bus decoder supplies single-cycle event strobes. These cover a read of the status register, a write of the command register together with the byte written, and a write of the device control register together with its byte. The decoder also supplies a level saying whether this drive is the one currently selected.

The busy flag in the status byte is forced to one by hardware when any of several host events occurs. Only the local controller can release it. A mode input separates ATAPI operation from the legacy compatibility modes. In those modes the trigger strobe and local status writes are ignored. Both outputs come straight from flip-flops, so every effect appears one clock after the event that causes it.

Top module: `atapi_hstat_irq`

## Requirements
- R1: A trigger strobe while `atapi_mode` is 1 drives `host_irq` to 1 on the next clock.
- R2: A host status read or a host command write drives `host_irq` to 0 on the next clock. When a trigger in ATAPI mode occurs in the same cycle, the trigger wins and `host_irq` is 1.
- R3: While `atapi_mode` is 0, a trigger strobe leaves `host_irq` unchanged.
- R4: A local status write while `atapi_mode` is 1 makes `host_status` equal the written byte on the next clock. While `atapi_mode` is 0, the write leaves `host_status` unchanged.
- R5: During and right after synchronous reset, `host_status` is 0x80 and `host_irq` is 0.
- R6: A host command write while `drv_sel_match` is 1 sets bit 7 (busy) of `host_status` on the next clock.
- R7: A host command write of 0x90 sets busy whatever the value of `drv_sel_match`. A command write of any other value while `drv_sel_match` is 0 leaves the status unchanged.
- R8: A host device control write with bit 2 set sets busy. With bit 2 clear, the write leaves the status unchanged.
- R9: When a hardware busy event and a local status write fall in the same cycle, the result holds bits 6..0 from the local byte and bit 7 as 1.
- R10: Busy goes from 1 to 0 only through a local status write in ATAPI mode whose bit 7 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| atapi_mode | input | 1 | 1 = ATAPI mode, 0 = compatibility mode |
| loc_stat_we | input | 1 | Local write strobe for the status byte |
| loc_stat_data | input | 8 | Status byte written by the local controller |
| loc_irq_trig | input | 1 | Local interrupt trigger strobe |
| host_stat_rd | input | 1 | Host read of the status register |
| host_cmd_we | input | 1 | Host write of the command register |
| host_cmd_data | input | 8 | Byte the host writes to the command register |
| host_dctl_we | input | 1 | Host write of the device control register |
| host_dctl_data | input | 8 | Byte the host writes to device control (bit 2 = soft reset) |
| drv_sel_match | input | 1 | This drive is currently selected |
| host_irq | output | 1 | Interrupt request to the host |
| host_status | output | 8 | Status byte presented to the host |

## Verification
Two pairs of functions can land on the same clock edge. In the first, a local status write that clears busy meets a host command or soft-reset write that sets busy. In the second, a local trigger meets a host status read or command write that clears the interrupt. The bench provokes each collision on purpose. It then continues with a long stretch of random strobes in which both collisions recur often. Every cycle is judged against a behavioural model that applies the precedence rules R9 and R2.

// File: rtl/atapi_hs_pkg.sv
package atapi_hs_pkg;

  typedef struct packed {
    logic stat_rd;
    logic cmd_we;
    logic dctl_we;
    logic drv_sel;
  } host_ev_t;

endpackage

// File: rtl/atapi_busy_detect.sv
module atapi_busy_detect
  import atapi_hs_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int          SRST_BIT = 2,
  parameter logic [7:0]  DIAG_CMD = 8'h90
) (
  input  host_ev_t            ev,
  input  logic [DATA_W-1:0]   cmd_data,
  input  logic [DATA_W-1:0]   dctl_data,
  output logic                busy_set,
  output logic                irq_clear
);

  logic cmd_selected;
  logic cmd_diag;
  logic soft_rst;
  logic unused_dctl;

  always_comb begin
    cmd_selected = ev.cmd_we && ev.drv_sel;
    cmd_diag     = ev.cmd_we && (cmd_data == DATA_W'(DIAG_CMD));
    soft_rst     = ev.dctl_we && dctl_data[SRST_BIT];
    busy_set     = cmd_selected || cmd_diag || soft_rst;
    irq_clear    = ev.stat_rd || ev.cmd_we;
  end

  assign unused_dctl = ^dctl_data;

endmodule

// File: rtl/atapi_status_reg.sv
module atapi_status_reg #(
  parameter int              DATA_W  = 8,
  parameter int              BSY_BIT = 7,
  parameter logic [DATA_W-1:0] RST_VAL = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_atapi,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy_set,
  output logic [DATA_W-1:0] stat_q
);

  logic              wr_ok;
  logic [DATA_W-1:0] stat_d;

  assign wr_ok = wr_en && mode_atapi;

  always_comb begin
    stat_d = stat_q;
    if (wr_ok) stat_d = wr_data;
    if (busy_set) stat_d[BSY_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= RST_VAL;
    else     stat_q <= stat_d;
  end

  // R5: reset value seen after release
  p_reset_val_r5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> stat_q == RST_VAL);

  // R6, R7, R8: any hardware busy event shows busy next cycle
  p_busy_set_r6: assert property (@(posedge clk) disable iff (rst)
    busy_set |=> stat_q[BSY_BIT]);

  // R9: collision keeps the low bits of the local byte
  p_collide_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_set && wr_ok) |=> stat_q[BSY_BIT-1:0] == $past(wr_data[BSY_BIT-1:0]));

  // R4: ignored local write in compatibility mode
  p_mode_ignore_r4: assert property (@(posedge clk) disable iff (rst)
    (!mode_atapi && !busy_set) |=> $stable(stat_q));

  // R10: busy falls only through a local write with busy clear
  p_busy_fall_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_q[BSY_BIT]) |-> $past(wr_ok && !wr_data[BSY_BIT]));

endmodule

// File: rtl/atapi_irq_ctl.sv
module atapi_irq_ctl (
  input  logic clk,
  input  logic rst,
  input  logic mode_atapi,
  input  logic trig,
  input  logic irq_clear,
  output logic irq_q
);

  logic fire;

  assign fire = trig && mode_atapi;

  always_ff @(posedge clk) begin
    if (rst)            irq_q <= 1'b0;
    else if (fire)      irq_q <= 1'b1;
    else if (irq_clear) irq_q <= 1'b0;
  end

  // R1: trigger in ATAPI mode raises the request
  p_irq_set_r1: assert property (@(posedge clk) disable iff (rst)
    fire |=> irq_q);

  // R2: host action clears when no trigger competes
  p_irq_clr_r2: assert property (@(posedge clk) disable iff (rst)
    (irq_clear && !fire) |=> !irq_q);

  // R3: no rise while in compatibility mode
  p_irq_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (!mode_atapi && !irq_q) |=> !irq_q);

  // R5: request low after reset
  p_irq_reset_r5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !irq_q);

endmodule

// File: rtl/atapi_hstat_irq.sv
module atapi_hstat_irq
  import atapi_hs_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int          BSY_BIT  = 7,
  parameter int          SRST_BIT = 2,
  parameter logic [7:0]  DIAG_CMD = 8'h90,
  parameter logic [7:0]  RST_VAL  = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              atapi_mode,
  input  logic              loc_stat_we,
  input  logic [DATA_W-1:0] loc_stat_data,
  input  logic              loc_irq_trig,
  input  logic              host_stat_rd,
  input  logic              host_cmd_we,
  input  logic [DATA_W-1:0] host_cmd_data,
  input  logic              host_dctl_we,
  input  logic [DATA_W-1:0] host_dctl_data,
  input  logic              drv_sel_match,
  output logic              host_irq,
  output logic [DATA_W-1:0] host_status
);

  host_ev_t ev;
  logic     busy_set;
  logic     irq_clear;

  assign ev = '{stat_rd: host_stat_rd, cmd_we: host_cmd_we,
                dctl_we: host_dctl_we, drv_sel: drv_sel_match};

  atapi_busy_detect #(
    .DATA_W(DATA_W), .SRST_BIT(SRST_BIT), .DIAG_CMD(DIAG_CMD)
  ) u_det (
    .ev(ev), .cmd_data(host_cmd_data), .dctl_data(host_dctl_data),
    .busy_set(busy_set), .irq_clear(irq_clear)
  );

  atapi_status_reg #(
    .DATA_W(DATA_W), .BSY_BIT(BSY_BIT), .RST_VAL(DATA_W'(RST_VAL))
  ) u_stat (
    .clk(clk), .rst(rst), .mode_atapi(atapi_mode),
    .wr_en(loc_stat_we), .wr_data(loc_stat_data),
    .busy_set(busy_set), .stat_q(host_status)
  );

  atapi_irq_ctl u_irq (
    .clk(clk), .rst(rst), .mode_atapi(atapi_mode),
    .trig(loc_irq_trig), .irq_clear(irq_clear), .irq_q(host_irq)
  );

  // R7: diagnostic command to an unselected drive still sets busy
  p_diag_r7: assert property (@(posedge clk) disable iff (rst)
    (host_cmd_we && !drv_sel_match && host_cmd_data == DATA_W'(DIAG_CMD))
      |=> host_status[BSY_BIT]);

  // R8: soft reset bit in device control sets busy
  p_srst_r8: assert property (@(posedge clk) disable iff (rst)
    (host_dctl_we && host_dctl_data[SRST_BIT]) |=> host_status[BSY_BIT]);

endmodule

// File: tb/sim_atapi_hstat_irq.sv
module sim_atapi_hstat_irq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       atapi_mode = 1'b0;
  logic       loc_stat_we = 1'b0;
  logic [7:0] loc_stat_data = '0;
  logic       loc_irq_trig = 1'b0;
  logic       host_stat_rd = 1'b0;
  logic       host_cmd_we = 1'b0;
  logic [7:0] host_cmd_data = '0;
  logic       host_dctl_we = 1'b0;
  logic [7:0] host_dctl_data = '0;
  logic       drv_sel_match = 1'b0;
  logic       host_irq;
  logic [7:0] host_status;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;
  string cur_req = "R5";

  int m_stat = 8'h80;
  int m_irq  = 0;

  always #5 clk = ~clk;

  atapi_hstat_irq u0 (.*);

  // behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    int ns;
    bit hw;
    cycles++;
    if (rst) begin
      m_stat = 8'h80;
      m_irq  = 0;
    end else begin
      hw = (host_cmd_we && (drv_sel_match || host_cmd_data == 8'h90))
        || (host_dctl_we && host_dctl_data[2]);
      ns = m_stat;
      if (atapi_mode && loc_stat_we) ns = loc_stat_data;
      if (hw) ns = ns | 8'h80;
      m_stat = ns;
      if (loc_irq_trig && atapi_mode) m_irq = 1;
      else if (host_stat_rd || host_cmd_we) m_irq = 0;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (host_status !== 8'(m_stat)) begin
        fails++;
        $display("FAIL %s host_status actual=%02h expected=%02h", cur_req, host_status, m_stat);
      end
      checks++;
      if (host_irq !== 1'(m_irq)) begin
        fails++;
        $display("FAIL %s host_irq actual=%0b expected=%0d", cur_req, host_irq, m_irq);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle();
    loc_stat_we = 0; loc_irq_trig = 0; host_stat_rd = 0;
    host_cmd_we = 0; host_dctl_we = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
    idle();
  endtask

  task automatic lwr(input logic [7:0] v);
    loc_stat_we = 1; loc_stat_data = v; tick();
  endtask

  task automatic hcmd(input logic [7:0] v, input logic sel);
    host_cmd_we = 1; host_cmd_data = v; drv_sel_match = sel; tick();
  endtask

  task automatic hdctl(input logic [7:0] v);
    host_dctl_we = 1; host_dctl_data = v; tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 0;
    cur_req = "R5"; tick(); tick();
    atapi_mode = 1;
    cur_req = "R4";  lwr(8'h41); tick();
    cur_req = "R10"; lwr(8'h7F); lwr(8'h00); tick();
    cur_req = "R1";  loc_irq_trig = 1; tick(); tick();
    cur_req = "R2";  host_stat_rd = 1; tick(); tick();
    loc_irq_trig = 1; tick();
    cur_req = "R7";  hcmd(8'h55, 0); tick();
    cur_req = "R2";  loc_irq_trig = 1; host_stat_rd = 1; tick(); tick();
    cur_req = "R6";  hcmd(8'hA0, 1); tick(); lwr(8'h00);
    cur_req = "R7";  hcmd(8'h90, 0); tick(); lwr(8'h00);
    cur_req = "R8";  hdctl(8'h04); tick(); lwr(8'h00); hdctl(8'hFB); tick();
    cur_req = "R9";  loc_stat_we = 1; loc_stat_data = 8'h01; host_dctl_we = 1;
    host_dctl_data = 8'h04; tick(); tick();
    loc_stat_we = 1; loc_stat_data = 8'h22; host_cmd_we = 1;
    host_cmd_data = 8'h90; drv_sel_match = 0; tick(); tick();
    cur_req = "R10"; hcmd(8'h12, 0); host_stat_rd = 1; tick(); lwr(8'h80); lwr(8'h3C);
    atapi_mode = 0;
    cur_req = "R3";  loc_irq_trig = 1; tick(); tick();
    cur_req = "R4";  lwr(8'h00); lwr(8'hFF); tick();
    cur_req = "R8";  hdctl(8'h04); tick();
    cur_req = "R4";  lwr(8'h00); tick();
    atapi_mode = 1;  lwr(8'h00);
    cur_req = "mixed";
    for (int i = 0; i < 2000; i++) begin
      atapi_mode     = ($urandom_range(0, 7) != 0);
      loc_stat_we    = ($urandom_range(0, 2) == 0);
      loc_stat_data  = 8'($urandom);
      loc_irq_trig   = ($urandom_range(0, 2) == 0);
      host_stat_rd   = ($urandom_range(0, 3) == 0);
      host_cmd_we    = ($urandom_range(0, 4) == 0);
      host_cmd_data  = ($urandom_range(0, 3) == 0) ? 8'h90 : 8'($urandom);
      host_dctl_we   = ($urandom_range(0, 4) == 0);
      host_dctl_data = 8'($urandom);
      drv_sel_match  = 1'($urandom);
      tick();
    end
    tick();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule